// File: doc/BRIEF.md
# Laser Transmitter Safety Supervisor

This block decides whether a laser transmitter may drive its bias and modulation currents. It watches a software enable bit, an external disable pin and three fault sources. The fault sources are an over-voltage flag from the bias-monitor comparator, an over-target flag from the photodiode comparator, and each update of the 10-bit bias DAC code, where the new code is compared against the old one. While fault detection is on, any fault turns both current enables off and sets a sticky fault flag.

The sticky flag clears only through a recovery pulse. Either the disable pin is held high or the enable bit is held low, and the pulse must last at least a set number of clock cycles. When the pulse ends, a fault condition that is still present sets the flag again at once. If the condition has gone, the current enables come back after a negate delay. After power-on reset the enables also wait for an initialise delay and then the negate delay, even when the enable bit is already set.

The timing is set by three parameters, all counted in clock cycles: `RST_W_CYC` (minimum recovery pulse), `NEGATE_CYC` (negate delay) and `INIT_CYC` (initialise delay). A raised comparator flag, or a bad code update, is seen at the next rising clock edge.

Top module: `laser_safety_supervisor`

## Requirements
- R1: The enables `bias_en` and `mod_en` are low in any cycle in which `en_bit` is 0 or `dis_pin` is 1. The change takes effect combinationally, with no clock edge needed.
- R2: After reset `fault` and both enables are 0. With `en_bit`=1 and `dis_pin`=0 held from reset release, the enables turn on at the `INIT_CYC`+`NEGATE_CYC`-th rising edge after release, and not before it.
- R3: With `flt_en`=1 and no recovery in progress, a 1 on `mon_ovr` or on `pd_ovr` sampled at an edge sets `fault` at that edge. From that edge on, both enables are 0.
- R4: With `flt_en`=1, an edge where `bias_wr`=1 and 2·`bias_new` < `bias_old` (both read as unsigned) sets `fault`. A code that is exactly half of the old one does not set it, and neither does any code while `bias_wr`=0.
- R5: With `flt_en`=0, no fault source sets `fault`, and the enables follow R1 and R8 only.
- R6: `fault` clears at the edge that samples the off request (`en_bit`=0 or `dis_pin`=1) for the `RST_W_CYC`-th consecutive time, and stays clear while that request holds. A shorter request leaves `fault` set.
- R7: If a comparator flag is still high when the off request ends after a recovery, `fault` sets again at the next edge and both enables stay 0.
- R8: When the off request ends and no fault is latched, the enables turn on at the `NEGATE_CYC`-th edge that samples the request low.
- R9: Once set, `fault` stays 1 after its source goes away, until a recovery pulse under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| en_bit | input | 1 | Software enable bit; 1 allows the currents |
| flt_en | input | 1 | Fault detection enable |
| dis_pin | input | 1 | External disable pin; 1 forces the currents off |
| mon_ovr | input | 1 | Bias-monitor over-voltage comparator flag |
| pd_ovr | input | 1 | Photodiode current over 150% of target flag |
| bias_wr | input | 1 | One-cycle strobe marking a bias code update |
| bias_new | input | CODE_W | Bias DAC code being written |
| bias_old | input | CODE_W | Bias DAC code before the update |
| bias_en | output | 1 | Bias current enable |
| mod_en | output | 1 | Modulation current enable |
| fault | output | 1 | Latched fault flag |

## Verification
The block is driven with the following patterns:
- Single-cycle comparator pulses, which separate a sticky flag from one that only follows its source.
- A comparator flag held high across a recovery pulse, which separates the re-latch case from a clean return.
- Disable pulses one cycle shorter than the minimum and exactly as long as it, which locate the recovery threshold to the cycle.
- Bias code updates just below half and at exactly half, plus an update to zero and a large drop without the write strobe, which separate the strict comparison and its strobe qualification.
- The same sources applied with detection turned off, which show that the latch is gated.

A behavioural model in the bench predicts every output on every clock.

// File: rtl/laser_safety_supervisor.sv
module laser_safety_supervisor #(
  parameter int CODE_W     = 10,
  parameter int RST_W_CYC  = 20,
  parameter int NEGATE_CYC = 64,
  parameter int INIT_CYC   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_bit,
  input  logic              flt_en,
  input  logic              dis_pin,
  input  logic              mon_ovr,
  input  logic              pd_ovr,
  input  logic              bias_wr,
  input  logic [CODE_W-1:0] bias_new,
  input  logic [CODE_W-1:0] bias_old,
  output logic              bias_en,
  output logic              mod_en,
  output logic              fault
);
  localparam int RW = $clog2(RST_W_CYC + 1);
  localparam int NW = $clog2(NEGATE_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  logic [RW-1:0] off_cnt;
  logic [NW-1:0] neg_cnt;
  logic [IW-1:0] init_cnt;
  logic          flt_q;

  logic off_req, init_done, ready, qual, drop_evt, cond;

  assign off_req   = ~en_bit | dis_pin;
  assign init_done = (init_cnt == IW'(INIT_CYC));
  assign ready     = (neg_cnt == NW'(NEGATE_CYC));
  assign qual      = off_req & (off_cnt >= RW'(RST_W_CYC - 1));
  assign drop_evt  = bias_wr & ({bias_new, 1'b0} < {1'b0, bias_old});
  assign cond      = mon_ovr | pd_ovr | drop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      off_cnt  <= '0;
      neg_cnt  <= '0;
      flt_q    <= 1'b0;
    end else begin
      if (!init_done) init_cnt <= init_cnt + IW'(1);

      if (!off_req) off_cnt <= '0;
      else if (off_cnt != RW'(RST_W_CYC)) off_cnt <= off_cnt + RW'(1);

      if (qual) flt_q <= 1'b0;
      else if (flt_en && cond) flt_q <= 1'b1;

      if (off_req || flt_q || !init_done) neg_cnt <= '0;
      else if (!ready) neg_cnt <= neg_cnt + NW'(1);
    end
  end

  assign bias_en = ~off_req & ~flt_q & init_done & ready;
  assign mod_en  = bias_en;
  assign fault   = flt_q;
endmodule

// File: rtl/laser_safety_supervisor_chk.sv
module laser_safety_supervisor_chk #(
  parameter int CODE_W     = 10,
  parameter int NEGATE_CYC = 64,
  parameter int INIT_CYC   = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_bit,
  input logic              flt_en,
  input logic              dis_pin,
  input logic              mon_ovr,
  input logic              pd_ovr,
  input logic              bias_wr,
  input logic [CODE_W-1:0] bias_new,
  input logic [CODE_W-1:0] bias_old,
  input logic              bias_en,
  input logic              mod_en,
  input logic              fault
);
  localparam logic [31:0] START_EDGES = 32'(INIT_CYC + NEGATE_CYC);
  logic [31:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != START_EDGES) since_rst <= since_rst + 32'd1;
  end

  a_r1_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit || dis_pin) |-> (!bias_en && !mod_en));

  a_r2_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bias_en |-> (since_rst == START_EDGES));

  a_r3_cmp_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && (mon_ovr || pd_ovr) && en_bit && !dis_pin) |=> fault);

  a_r3_fault_gates: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!bias_en && !mod_en));

  a_r4_drop_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && bias_wr && ({bias_new, 1'b0} < {1'b0, bias_old}) && en_bit && !dis_pin) |=> fault);

  a_r5_no_latch_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_en && !fault) |=> !fault);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en_bit && !dis_pin) |=> fault);
endmodule

bind laser_safety_supervisor laser_safety_supervisor_chk #(
  .CODE_W(CODE_W), .NEGATE_CYC(NEGATE_CYC), .INIT_CYC(INIT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_bit(en_bit), .flt_en(flt_en), .dis_pin(dis_pin),
  .mon_ovr(mon_ovr), .pd_ovr(pd_ovr), .bias_wr(bias_wr), .bias_new(bias_new),
  .bias_old(bias_old), .bias_en(bias_en), .mod_en(mod_en), .fault(fault)
);

// File: tb/tb_laser_safety_supervisor.sv
`timescale 1ns/1ps
module tb_laser_safety_supervisor;
  localparam int CODE_W = 10;
  localparam int RST_W  = 20;
  localparam int NEG    = 64;
  localparam int INIT   = 40;

  logic clk = 0, rst_n = 0;
  logic en_bit = 1, flt_en = 1, dis_pin = 0, mon_ovr = 0, pd_ovr = 0, bias_wr = 0;
  logic [CODE_W-1:0] bias_new = '0, bias_old = '0;
  logic bias_en, mod_en, fault;

  laser_safety_supervisor dut (
    .clk(clk), .rst_n(rst_n), .en_bit(en_bit), .flt_en(flt_en), .dis_pin(dis_pin),
    .mon_ovr(mon_ovr), .pd_ovr(pd_ovr), .bias_wr(bias_wr), .bias_new(bias_new),
    .bias_old(bias_old), .bias_en(bias_en), .mod_en(mod_en), .fault(fault)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string phase = "R2";
  bit done = 0;

  int m_init = 0, m_off = 0, m_neg = 0;
  bit m_flt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_init = 0; m_off = 0; m_neg = 0; m_flt = 0;
    end else begin
      bit off, drop, cond, nflt;
      int noff;
      off  = !en_bit || dis_pin;
      drop = bias_wr && (2 * int'(bias_new) < int'(bias_old));
      cond = mon_ovr || pd_ovr || drop;
      noff = off ? m_off + 1 : 0;
      if (off && noff >= RST_W) nflt = 0;
      else if (flt_en && cond) nflt = 1;
      else nflt = m_flt;
      if (off || m_flt || m_init < INIT) m_neg = 0;
      else if (m_neg < NEG) m_neg = m_neg + 1;
      if (m_init < INIT) m_init = m_init + 1;
      m_off = noff;
      m_flt = nflt;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit exp_on;
      exp_on = en_bit && !dis_pin && !m_flt && m_init >= INIT && m_neg >= NEG;
      checks++;
      if (bias_en !== exp_on || mod_en !== exp_on || fault !== m_flt) begin
        errors++;
        $display("FAIL %s @%0t: bias_en=%0b mod_en=%0b fault=%0b expected en=%0b fault=%0b",
                 phase, $time, bias_en, mod_en, fault, exp_on, m_flt);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic recover();
    dis_pin = 1; cyc(RST_W);
    dis_pin = 0; cyc(NEG);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    phase = "R2";
    cyc(3);
    chk("R2", "fault in reset", fault, 1'b0);
    chk("R2", "bias_en in reset", bias_en, 1'b0);
    rst_n = 1;
    cyc(INIT + NEG - 1);
    chk("R2", "bias_en before delays expire", bias_en, 1'b0);
    cyc(1);
    chk("R2", "bias_en after init and negate", bias_en, 1'b1);

    phase = "R1";
    dis_pin = 1; #0.5;
    chk("R1", "bias_en with dis_pin high", bias_en, 1'b0);
    cyc(3);
    dis_pin = 0;
    phase = "R8";
    cyc(NEG - 1);
    chk("R8", "bias_en one edge before negate end", bias_en, 1'b0);
    cyc(1);
    chk("R8", "bias_en at negate end", bias_en, 1'b1);
    phase = "R1";
    en_bit = 0; #0.5;
    chk("R1", "mod_en with en_bit low", mod_en, 1'b0);
    cyc(4);
    en_bit = 1; cyc(NEG);
    chk("R1", "bias_en after re-enable", bias_en, 1'b1);

    phase = "R3";
    mon_ovr = 1; cyc(1);
    chk("R3", "fault after monitor flag", fault, 1'b1);
    chk("R3", "bias_en after monitor flag", bias_en, 1'b0);
    mon_ovr = 0;
    phase = "R9";
    cyc(6);
    chk("R9", "fault stays latched", fault, 1'b1);

    phase = "R6";
    dis_pin = 1; cyc(RST_W - 1);
    chk("R6", "fault during short pulse", fault, 1'b1);
    dis_pin = 0; cyc(2);
    chk("R6", "fault after short pulse", fault, 1'b1);
    dis_pin = 1; cyc(RST_W);
    chk("R6", "fault cleared by full pulse", fault, 1'b0);
    chk("R6", "bias_en during pulse", bias_en, 1'b0);
    cyc(3);
    dis_pin = 0;
    phase = "R8";
    cyc(NEG);
    chk("R8", "bias_en back after clean recovery", bias_en, 1'b1);

    phase = "R7";
    pd_ovr = 1; cyc(1);
    chk("R3", "fault after photodiode flag", fault, 1'b1);
    dis_pin = 1; cyc(RST_W + 2);
    chk("R6", "fault clears while disabled", fault, 1'b0);
    dis_pin = 0; cyc(1);
    chk("R7", "fault re-asserts on release", fault, 1'b1);
    cyc(NEG + 2);
    chk("R7", "bias_en stays off", bias_en, 1'b0);
    pd_ovr = 0;
    en_bit = 0; cyc(RST_W);
    chk("R6", "fault cleared by enable-bit pulse", fault, 1'b0);
    en_bit = 1; cyc(NEG);
    chk("R8", "bias_en after enable-bit recovery", bias_en, 1'b1);

    phase = "R4";
    bias_old = 10'd201; bias_new = 10'd100; bias_wr = 1; cyc(1);
    bias_wr = 0;
    chk("R4", "fault on drop 201->100", fault, 1'b1);
    recover();
    bias_old = 10'd200; bias_new = 10'd100; bias_wr = 1; cyc(1);
    bias_wr = 0;
    chk("R4", "no fault on exact half 200->100", fault, 1'b0);
    bias_old = 10'd1023; bias_new = 10'd0; cyc(2);
    chk("R4", "no fault without strobe", fault, 1'b0);
    chk("R4", "bias_en unaffected without strobe", bias_en, 1'b1);
    bias_old = 10'd1; bias_new = 10'd0; bias_wr = 1; cyc(1);
    bias_wr = 0;
    chk("R4", "fault on drop 1->0", fault, 1'b1);
    recover();
    bias_old = 10'd0; bias_new = 10'd0; bias_wr = 1; cyc(1);
    bias_wr = 0;
    chk("R4", "no fault on 0->0", fault, 1'b0);

    phase = "R5";
    flt_en = 0; mon_ovr = 1; pd_ovr = 1; cyc(5);
    chk("R5", "no fault with detection off", fault, 1'b0);
    chk("R5", "bias_en stays on with detection off", bias_en, 1'b1);
    bias_old = 10'd900; bias_new = 10'd3; bias_wr = 1; cyc(1);
    bias_wr = 0;
    chk("R5", "no fault on drop with detection off", fault, 1'b0);
    chk("R5", "mod_en stays on with detection off", mod_en, 1'b1);
    mon_ovr = 0; pd_ovr = 0; flt_en = 1; cyc(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule